// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble

This block turns bytes written by a host into asynchronous serial frames of one low start bit, the data bits least significant first, and one high stop bit (no parity). The line moves only on a one-cycle bit tick that an outside rate generator supplies, so every bit lasts one tick period. A byte waits in a holding register, and a status flag shows whether that register is free. The byte moves into a shift register only at the moment a start bit is due, and the flag rises in that same cycle.

Turning the transmitter on does not start a frame at once. The sequencer first drives a fixed run of idle-high bit times, ten by default. Only after that run can a start bit go out. While the transmitter is on, it takes over one pin of a small general-purpose port: it forces that pin to be an output and drives the serial level onto it. When the transmitter is turned off, the pin goes back to the port's own direction and value. An interrupt line is high while the holding register is free and the interrupt enable is set.

Top module: `async_tx_unit`

## Requirements
- R1: After reset the empty flag `tdre_o` is 1, `irq_o` is 0, the transmitter is off, and every pin of `pin_oe_o`/`pin_val_o` equals the matching bit of `port_dir_i`/`port_val_i`.
- R2: A data write (`wr_data_en_i`=1) stores `wr_data_i` and clears `tdre_o` in the next cycle. If a write lands in the same cycle as a load, the shift register takes the older byte and `tdre_o` stays 0.
- R3: After the control write sets enable, the first PREAMBLE_LEN (10) ticks each drive the line to 1. The earliest start bit comes on tick PREAMBLE_LEN+1.
- R4: At a start-bit slot with `tdre_o`=1, the line stays 1 and no frame begins.
- R5: At a start-bit slot with `tdre_o`=0, the line goes to 0 and `tdre_o` becomes 1 in the same cycle.
- R6: The next DATA_W ticks after a start bit send the loaded byte, bit 0 first, one bit per tick.
- R7: The tick after the last data bit drives a 1 stop bit. The tick after that is again a start-bit slot, so frames can follow back to back.
- R8: The serial level changes only on a cycle where `bit_tick_i` is 1. Cycles without a tick leave it unchanged.
- R9: Clearing enable sends the sequencer back to the preamble with its count at 0, and gives pin TX_BIT back to the port. Enabling again repeats the full preamble.
- R10: While enabled, `pin_oe_o[TX_BIT]` (bit 4) is 1 and `pin_val_o[TX_BIT]` carries the serial level, whatever `port_dir_i[4]` is. The other pins always follow the port.
- R11: `irq_o` is 1 exactly when `tdre_o` is 1 and the interrupt-enable bit (`ctl_ie_i` at the last control write) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_data_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| wr_ctl_en_i | input | 1 | Write strobe for the control bits |
| ctl_te_i | input | 1 | Transmit enable value for a control write |
| ctl_ie_i | input | 1 | Interrupt enable value for a control write |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| port_dir_i | input | PORT_W | Port direction bits (1 = output) |
| port_val_i | input | PORT_W | Port output values |
| pin_oe_o | output | PORT_W | Resolved pin output enables |
| pin_val_o | output | PORT_W | Resolved pin output values |
| tdre_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
Five bytes go through the framer back to back: 0x55, 0xA3, 0x00, 0xFF and 0x81. Alternating bits, all zeros, all ones and bytes set only at the ends separate LSB-first order from MSB-first order, and show whether a stuck or shifted bit lines up with the start or the stop bit. Idle ticks with no data show that no frame starts on its own, and a long gap between ticks shows the line holds its level. Turning enable off mid-frame and back on, with the port direction bit for the serial pin at 0, checks that the preamble is counted again from zero and that the pin override is applied and released.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   typedef enum logic {
      PH_PREAMBLE = 1'b0,
      PH_FRAMING  = 1'b1
   } tx_phase_e;

   function automatic int unsigned slot_width(input int unsigned data_w);
      return $clog2(data_w + 2);
   endfunction

endpackage

// File: rtl/async_tx_regs.sv
module async_tx_regs #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_ctl_en_i,
   input  logic              ctl_te_i,
   input  logic              ctl_ie_i,
   input  logic              load_i,
   output logic [DATA_W-1:0] hold_q_o,
   output logic              tdre_o,
   output logic              te_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] hold_q;
   logic              tdre_q;
   logic              te_q;
   logic              ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         tdre_q <= 1'b1;
      end else if (wr_data_en_i) begin
         hold_q <= wr_data_i;
         tdre_q <= 1'b0;
      end else if (load_i) begin
         tdre_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_q <= 1'b0;
         ie_q <= 1'b0;
      end else if (wr_ctl_en_i) begin
         te_q <= ctl_te_i;
         ie_q <= ctl_ie_i;
      end
   end

   assign hold_q_o = hold_q;
   assign tdre_o   = tdre_q;
   assign te_o     = te_q;
   assign irq_o    = tdre_q & ie_q;

   // R2
   wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_en_i |=> !tdre_q);

   // R5
   load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !wr_data_en_i) |=> tdre_q);

endmodule

// File: rtl/async_tx_seq.sv
module async_tx_seq
   import async_tx_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PREAMBLE_LEN = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              te_i,
   input  logic              bit_tick_i,
   input  logic              tdre_i,
   input  logic [DATA_W-1:0] hold_i,
   output logic              load_o,
   output logic              tx_o
);

   localparam int unsigned SLOT_W = slot_width(DATA_W);
   localparam int unsigned PC_W   = $clog2(PREAMBLE_LEN + 1);
   localparam logic [SLOT_W-1:0] START_SLOT = '0;
   localparam logic [SLOT_W-1:0] STOP_SLOT  = SLOT_W'(DATA_W + 1);
   localparam logic [PC_W-1:0]   PRE_LAST   = PC_W'(PREAMBLE_LEN - 1);

   tx_phase_e         phase;
   logic [PC_W-1:0]   pre_cnt;
   logic [SLOT_W-1:0] slot;
   logic [DATA_W-1:0] shreg;
   logic              tx_q;

   assign load_o = te_i & bit_tick_i & (phase == PH_FRAMING)
                 & (slot == START_SLOT) & ~tdre_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_PREAMBLE;
         pre_cnt <= '0;
         slot    <= START_SLOT;
         shreg   <= '0;
         tx_q    <= 1'b1;
      end else if (!te_i) begin
         phase   <= PH_PREAMBLE;
         pre_cnt <= '0;
         slot    <= START_SLOT;
         tx_q    <= 1'b1;
      end else if (bit_tick_i) begin
         unique case (phase)
            PH_PREAMBLE: begin
               tx_q <= 1'b1;
               if (pre_cnt == PRE_LAST) begin
                  phase   <= PH_FRAMING;
                  pre_cnt <= '0;
                  slot    <= START_SLOT;
               end else begin
                  pre_cnt <= pre_cnt + 1'b1;
               end
            end
            PH_FRAMING: begin
               if (slot == START_SLOT) begin
                  if (!tdre_i) begin
                     shreg <= hold_i;
                     tx_q  <= 1'b0;
                     slot  <= slot + 1'b1;
                  end
               end else if (slot == STOP_SLOT) begin
                  tx_q <= 1'b1;
                  slot <= START_SLOT;
               end else begin
                  tx_q  <= shreg[0];
                  shreg <= {1'b0, shreg[DATA_W-1:1]};
                  slot  <= slot + 1'b1;
               end
            end
            default: begin
               phase <= PH_PREAMBLE;
            end
         endcase
      end
   end

   assign tx_o = tx_q;

   // R3
   preamble_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PREAMBLE) |-> tx_q);

   // R5
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> (!tx_q && slot == SLOT_W'(1)));

   // R8
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (te_i && !bit_tick_i) |=> ($stable(tx_q) && $stable(slot)));

   // R7
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= STOP_SLOT);

endmodule

// File: rtl/async_tx_pinmux.sv
module async_tx_pinmux #(
   parameter int unsigned PORT_W = 5,
   parameter int unsigned TX_BIT = 4
) (
   input  logic              te_i,
   input  logic              tx_i,
   input  logic [PORT_W-1:0] port_dir_i,
   input  logic [PORT_W-1:0] port_val_i,
   output logic [PORT_W-1:0] pin_oe_o,
   output logic [PORT_W-1:0] pin_val_o
);

   for (genvar g = 0; g < PORT_W; g++) begin : g_pin
      if (g == TX_BIT) begin : g_serial
         assign pin_oe_o[g]  = te_i ? 1'b1 : port_dir_i[g];
         assign pin_val_o[g] = te_i ? tx_i : port_val_i[g];
      end else begin : g_plain
         assign pin_oe_o[g]  = port_dir_i[g];
         assign pin_val_o[g] = port_val_i[g];
      end
   end

endmodule

// File: rtl/async_tx_unit.sv
module async_tx_unit #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PREAMBLE_LEN = 10,
   parameter int unsigned PORT_W       = 5,
   parameter int unsigned TX_BIT       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_ctl_en_i,
   input  logic              ctl_te_i,
   input  logic              ctl_ie_i,
   input  logic              bit_tick_i,
   input  logic [PORT_W-1:0] port_dir_i,
   input  logic [PORT_W-1:0] port_val_i,
   output logic [PORT_W-1:0] pin_oe_o,
   output logic [PORT_W-1:0] pin_val_o,
   output logic              tdre_o,
   output logic              irq_o
);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data_w
      $error("async_tx_unit: DATA_W must lie in 5..16");
   end
   if (PREAMBLE_LEN < 1) begin : g_bad_preamble
      $error("async_tx_unit: PREAMBLE_LEN must be at least 1");
   end
   if (TX_BIT >= PORT_W) begin : g_bad_tx_bit
      $error("async_tx_unit: TX_BIT must index a port pin");
   end

   logic [DATA_W-1:0] hold_q;
   logic              te;
   logic              load;
   logic              tx;
   logic              tdre;

   async_tx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_data_en_i (wr_data_en_i),
      .wr_data_i    (wr_data_i),
      .wr_ctl_en_i  (wr_ctl_en_i),
      .ctl_te_i     (ctl_te_i),
      .ctl_ie_i     (ctl_ie_i),
      .load_i       (load),
      .hold_q_o     (hold_q),
      .tdre_o       (tdre),
      .te_o         (te),
      .irq_o        (irq_o)
   );

   async_tx_seq #(.DATA_W(DATA_W), .PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .te_i       (te),
      .bit_tick_i (bit_tick_i),
      .tdre_i     (tdre),
      .hold_i     (hold_q),
      .load_o     (load),
      .tx_o       (tx)
   );

   async_tx_pinmux #(.PORT_W(PORT_W), .TX_BIT(TX_BIT)) u_pins (
      .te_i       (te),
      .tx_i       (tx),
      .port_dir_i (port_dir_i),
      .port_val_i (port_val_i),
      .pin_oe_o   (pin_oe_o),
      .pin_val_o  (pin_val_o)
   );

   assign tdre_o = tdre;

   // R10
   pin_forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      te |-> pin_oe_o[TX_BIT]);

   // R11
   irq_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> tdre_o);

endmodule

// File: tb/sim_async_tx_unit.sv
`timescale 1ns/1ps
module sim_async_tx_unit;

   localparam int DATA_W = 8;
   localparam int PRE    = 10;
   localparam int PORT_W = 5;
   localparam int TXB    = 4;
   localparam int NVEC   = 5;
   localparam logic [DATA_W-1:0] VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_data_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic wr_ctl_en = 1'b0, ctl_te = 1'b0, ctl_ie = 1'b0;
   logic bit_tick = 1'b0;
   logic [PORT_W-1:0] port_dir = 5'b01010;
   logic [PORT_W-1:0] port_val = 5'b00101;
   logic [PORT_W-1:0] pin_oe, pin_val;
   logic tdre, irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   async_tx_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_data_en_i(wr_data_en), .wr_data_i(wr_data),
      .wr_ctl_en_i(wr_ctl_en), .ctl_te_i(ctl_te), .ctl_ie_i(ctl_ie),
      .bit_tick_i(bit_tick),
      .port_dir_i(port_dir), .port_val_i(port_val),
      .pin_oe_o(pin_oe), .pin_val_o(pin_val),
      .tdre_o(tdre), .irq_o(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic write_byte(input logic [DATA_W-1:0] b);
      @(negedge clk) begin wr_data_en = 1'b1; wr_data = b; end
      @(negedge clk) wr_data_en = 1'b0;
   endtask

   task automatic write_ctl(input logic te, input logic ie);
      @(negedge clk) begin wr_ctl_en = 1'b1; ctl_te = te; ctl_ie = ie; end
      @(negedge clk) wr_ctl_en = 1'b0;
   endtask

   function automatic logic line();
      return pin_val[TXB];
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 tdre", tdre, 1);
      check("R1 irq", irq, 0);
      check("R1 oe", pin_oe, port_dir);
      check("R1 val", pin_val, port_val);

      write_ctl(1'b1, 1'b1);
      // R10 override while enabled (port_dir[4]=0)
      check("R10 oe", pin_oe, {1'b1, port_dir[3:0]});
      check("R10 idle", line(), 1);
      // R11 irq follows empty && ie
      check("R11 irq on", irq, 1);

      write_byte(VEC[0]);
      // R2 write clears empty
      check("R2 tdre", tdre, 0);
      check("R11 irq off", irq, 0);

      // R3 preamble of ten idle ticks even with data waiting
      for (int k = 0; k < PRE; k++) begin
         tick();
         check("R3 preamble", line(), 1);
         check("R3 still full", tdre, 0);
      end

      // Table walk: back-to-back frames
      for (int i = 0; i < NVEC; i++) begin
         tick();
         check("R5 start", line(), 0);
         check("R5 tdre set", tdre, 1);
         if (i < NVEC - 1) begin
            write_byte(VEC[i+1]);
            check("R2 tdre clr", tdre, 0);
         end
         for (int b = 0; b < DATA_W; b++) begin
            tick();
            check("R6 data bit", line(), VEC[i][b]);
         end
         tick();
         check("R7 stop", line(), 1);
      end

      // R4 empty: start slots stay idle
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R4 idle", line(), 1);
         check("R4 tdre", tdre, 1);
      end

      // R8 level holds without ticks
      write_byte(8'hC3);
      tick();
      check("R8 start", line(), 0);
      repeat (7) @(negedge clk);
      check("R8 hold", line(), 0);
      tick();
      check("R8 bit0", line(), 1);

      // R9 disable mid-frame releases pin
      write_ctl(1'b0, 1'b1);
      check("R9 oe released", pin_oe, port_dir);
      check("R9 val released", pin_val, port_val);
      tick();
      check("R9 no drive", pin_val, port_val);

      // R9 re-enable: full preamble again
      write_ctl(1'b1, 1'b0);
      // R11 ie cleared
      check("R11 ie off", irq, 0);
      write_byte(8'h3C);
      for (int k = 0; k < PRE; k++) begin
         tick();
         check("R9 preamble", line(), 1);
      end
      tick();
      check("R9 start after preamble", line(), 0);
      for (int b = 0; b < DATA_W; b++) begin
         tick();
         check("R6 data bit 3C", line(), 8'h3C >> b & 1);
      end
      tick();
      check("R7 stop 3C", line(), 1);
      check("R11 ie off empty", irq, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule